// File: doc/BRIEF.md
# Multi-Mode 8x8 Multiplier

This block multiplies two 8-bit operands and returns a 16-bit product as a low byte and a high byte. The low byte is meant for destination register 0 and the high byte for destination register 1 of a fixed register pair. A 3-bit mode input selects one of six operations. The operands can be treated as unsigned by unsigned, signed by signed, or signed by unsigned, and each of these has an integer form and a fractional form. The fractional form shifts the product left by one bit, as Q1.7 arithmetic needs. The block also produces a carry flag and a zero flag. Both flags always describe the product before any fractional shift.

The caller drives the operands and the mode and pulses `start` for one cycle. A parameter selects how the result is returned. In the registered form (the default), the result and `valid` appear one cycle after `start`, and the result then holds until the next `start`. In the combinational form, the result and `valid` follow the inputs in the same cycle. The register file is outside this block.

Top module: `frac_mul_unit`

## Requirements
- R1: The mode is 3 bits. Bit 2 selects fractional (1) or integer (0). Bits 1:0 select the signedness: 00 unsigned x unsigned, 01 signed x signed, 10 signed x unsigned. In integer unsigned mode, `prod_lo` is bits 7:0 and `prod_hi` is bits 15:8 of the 16-bit product.
- R2: In signed x signed mode, both operands are sign-extended from bit 7 before multiplying, and the product is truncated to 16 bits.
- R3: In signed x unsigned mode, only `op_a` is sign-extended. `op_b` is taken as unsigned. Signedness code 11 behaves the same as 10.
- R4: In fractional modes, the output is the 16-bit product shifted left by one. The old bit 15 is dropped and bit 0 of `prod_lo` is 0.
- R5: `flag_c` equals bit 15 of the unshifted 16-bit product.
- R6: `flag_z` is 1 exactly when the unshifted 16-bit product is zero.
- R7: In the registered form, `valid` is high for exactly the one cycle after each `start` cycle, and low at all other times.
- R8: In the registered form, the product and the flags keep their values while `start` is low.
- R9: While reset is active and after it, until the first `start`, `valid`, the product bytes and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request that captures the operands and the mode |
| mode | input | 3 | Bit 2 selects fractional; bits 1:0 select signedness |
| op_a | input | 8 | First operand (signed in both signed modes) |
| op_b | input | 8 | Second operand (signed only in signed x signed mode) |
| valid | output | 1 | Result-ready strobe |
| prod_lo | output | 8 | Low byte of the result, for destination register 0 |
| prod_hi | output | 8 | High byte of the result, for destination register 1 |
| flag_c | output | 1 | Bit 15 of the unshifted product |
| flag_z | output | 1 | Unshifted product equals zero |

## Verification
Every result of the registered form is due on the first rising edge after the `start` cycle. The bench raises `start` on a falling edge and lowers it on the next falling edge. It then samples the product, the flags and `valid` on that same falling edge, half a period after the capturing edge. One cycle later it samples again, checking that `valid` has dropped while the product and the flags are unchanged. The flag checks use products whose unshifted and shifted forms disagree on bit 15 or on zero, so that taking a flag from the wrong form shows up.

// File: rtl/mulu_pkg.sv
package mulu_pkg;
    localparam int OP_W   = 8;
    localparam int PROD_W = 2 * OP_W;

    typedef enum logic [1:0] {
        SGN_UU  = 2'b00,
        SGN_SS  = 2'b01,
        SGN_SU  = 2'b10,
        SGN_SU2 = 2'b11
    } sign_sel_e;

    typedef struct packed {
        logic      frac;
        sign_sel_e sgn;
    } mode_t;

    typedef struct packed {
        logic [PROD_W-1:0] word;
        logic              c;
        logic              z;
    } result_t;

    function automatic logic [OP_W:0] widen(input logic [OP_W-1:0] v, input logic sgn);
        return {sgn & v[OP_W-1], v};
    endfunction
endpackage

// File: rtl/mulu_signer.sv
module mulu_signer
    import mulu_pkg::*;
#(
    parameter int W = OP_W
) (
    input  mode_t      mode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   ea,
    output logic [W:0]   eb
);
    logic a_signed;
    logic b_signed;

    always_comb begin
        a_signed = (mode.sgn != SGN_UU);
        b_signed = (mode.sgn == SGN_SS);
        ea = {a_signed & a[W-1], a};
        eb = {b_signed & b[W-1], b};
    end
endmodule

// File: rtl/mulu_core.sv
module mulu_core
    import mulu_pkg::*;
#(
    parameter int W = OP_W
) (
    input  logic [W:0] ea,
    input  logic [W:0] eb,
    input  logic       frac,
    output result_t    res
);
    localparam int PW = 2 * W;
    localparam int FW = 2 * W + 2;

    logic signed [FW-1:0] full;
    logic [PW-1:0]        raw;

    always_comb begin
        full     = $signed(ea) * $signed(eb);
        raw      = full[PW-1:0];
        res.c    = raw[PW-1];
        res.z    = (raw == '0);
        res.word = frac ? {raw[PW-2:0], 1'b0} : raw;
    end

    always_comb begin
        // R4
        if (frac) frac_lsb_clear_chk: assert (res.word[0] == 1'b0);
        // R5
        if (!frac) int_carry_top_chk: assert (res.word[PW-1] == res.c);
        // R6
        if (res.z) zero_word_chk: assert (res.word == '0);
    end
endmodule

// File: rtl/mulu_stage.sv
module mulu_stage
    import mulu_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  result_t res_in,
    output logic    valid,
    output result_t res_out
);
    generate
        if (REGISTERED) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    valid   <= 1'b0;
                    res_out <= '0;
                end else begin
                    valid <= start;
                    if (start) res_out <= res_in;
                end
            end

            // R7
            valid_after_start_chk: assert property (@(posedge clk) disable iff (rst)
                start |=> valid);
            // R7
            valid_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
                !start |=> !valid);
            // R8
            hold_between_starts_chk: assert property (@(posedge clk) disable iff (rst)
                !start |=> $stable(res_out));
        end else begin : g_comb
            always_comb begin
                valid   = start;
                res_out = res_in;
            end
        end
    endgenerate
endmodule

// File: rtl/frac_mul_unit.sv
module frac_mul_unit
    import mulu_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [2:0]      mode,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    output logic            valid,
    output logic [OP_W-1:0] prod_lo,
    output logic [OP_W-1:0] prod_hi,
    output logic            flag_c,
    output logic            flag_z
);
    mode_t       mode_s;
    logic [OP_W:0] ea;
    logic [OP_W:0] eb;
    result_t     res_comb;
    result_t     res_q;

    assign mode_s = mode_t'(mode);

    mulu_signer #(.W(OP_W)) u_signer (
        .mode (mode_s),
        .a    (op_a),
        .b    (op_b),
        .ea   (ea),
        .eb   (eb)
    );

    mulu_core #(.W(OP_W)) u_core (
        .ea   (ea),
        .eb   (eb),
        .frac (mode_s.frac),
        .res  (res_comb)
    );

    mulu_stage #(.REGISTERED(REGISTERED)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .res_in  (res_comb),
        .valid   (valid),
        .res_out (res_q)
    );

    assign prod_lo = res_q.word[OP_W-1:0];
    assign prod_hi = res_q.word[PROD_W-1:OP_W];
    assign flag_c  = res_q.c;
    assign flag_z  = res_q.z;
endmodule

// File: tb/frac_mul_unit_test.sv
module frac_mul_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] mode = 3'b000;
    logic [7:0] op_a = 8'h00;
    logic [7:0] op_b = 8'h00;
    logic       valid;
    logic [7:0] prod_lo;
    logic [7:0] prod_hi;
    logic       flag_c;
    logic       flag_z;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    frac_mul_unit uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .op_a(op_a), .op_b(op_b), .valid(valid),
        .prod_lo(prod_lo), .prod_hi(prod_hi),
        .flag_c(flag_c), .flag_z(flag_z)
    );

    task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [18:0] model(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
        int ia, ib, p;
        logic [15:0] p16, w;
        ia = (m[1:0] != 2'b00) ? int'($signed(a)) : int'(a);
        ib = (m[1:0] == 2'b01) ? int'($signed(b)) : int'(b);
        p = ia * ib;
        p16 = p[15:0];
        w = m[2] ? {p16[14:0], 1'b0} : p16;
        return {1'b1, w, p16[15], (p16 == 16'h0)};
    endfunction

    task automatic run_case(input string req, input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
        logic [18:0] exp;
        logic [17:0] held;
        exp = model(m, a, b);
        @(negedge clk);
        start = 1'b1; mode = m; op_a = a; op_b = b;
        @(negedge clk);
        start = 1'b0; op_a = ~a; op_b = ~b;
        check(req, {valid, prod_hi, prod_lo, flag_c, flag_z}, exp);
        held = {prod_hi, prod_lo, flag_c, flag_z};
        @(negedge clk);
        check("R7 valid one cycle", {18'h0, valid}, 19'h0);
        check("R8 hold", {1'b0, prod_hi, prod_lo, flag_c, flag_z}, {1'b0, held});
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset state", {valid, prod_hi, prod_lo, flag_c, flag_z}, 19'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 idle after reset", {valid, prod_hi, prod_lo, flag_c, flag_z}, 19'h0);

        run_case("R1 uu int 255*255",      3'b000, 8'hFF, 8'hFF);
        run_case("R1 uu int 13*7",         3'b000, 8'd13, 8'd7);
        run_case("R6 uu zero product",     3'b000, 8'h00, 8'h5A);
        run_case("R2 ss int -128*-128",    3'b001, 8'h80, 8'h80);
        run_case("R2 ss int -1*1",         3'b001, 8'hFF, 8'h01);
        run_case("R3 su int -1*255",       3'b010, 8'hFF, 8'hFF);
        run_case("R3 code 11 as su",       3'b011, 8'h81, 8'hC0);
        run_case("R4 uu frac drop top",    3'b100, 8'hFF, 8'hFF);
        run_case("R5 ss frac flags unshifted", 3'b101, 8'h80, 8'h80);
        run_case("R4 ss frac -1*1",        3'b101, 8'hFF, 8'h01);
        run_case("R5 uu frac 0x80*0x80",   3'b100, 8'h80, 8'h80);
        run_case("R6 frac shifted zero",   3'b110, 8'h00, 8'h80);
        run_case("R3 su frac",             3'b110, 8'hC0, 8'h40);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule